// File: doc/BRIEF.md
# Mask-Gated Subsampled Block-Matching Engine

This block performs an exhaustive motion search for one square current block against a reference search window. Every candidate displacement is scored by a subsampled sum of absolute differences (SSAD). Only pixels whose per-pixel mask bit is set contribute to that score. The engine reports the displacement with the lowest score. The mask comes from an external edge or subsample pattern generator. Clearing a mask bit freezes the matching processing element, so lowering mask density lowers switching activity in the array.

The array holds one current pixel and one mask bit per element. Each element adds its gated absolute difference to the partial sum arriving from the element above and passes the result down. The N column sums enter a registered adder tree. A compare-and-select stage then keeps the running minimum and its displacement. Reference data arrives one window column at a time, and the columns shift leftwards through the array.

The control state machine has five states. ST_IDLE waits for `start`. ST_LOAD_CUR takes N current rows. ST_FILL_REF takes the first N-1 columns of a window row band. ST_SCAN scores one candidate per accepted column. ST_DRAIN empties the result pipeline. The transitions are:
- start: ST_IDLE to ST_LOAD_CUR.
- last current row: ST_LOAD_CUR to ST_FILL_REF.
- array full: ST_FILL_REF to ST_SCAN.
- band end: ST_SCAN to ST_FILL_REF, when more bands remain.
- final column: ST_SCAN to ST_DRAIN.
- result out: ST_DRAIN to ST_IDLE.

Top module: `ssad_matcher`

## Requirements
- R1: The score of displacement (u,v) is the sum, over all (i,j) whose mask bit is 1, of |W(i+u, j+v) - C(i,j)|. Here C(i,j) is the current pixel at row i, column j. W(r,c) is the window pixel at row r, column c, and window coordinates run from -P upward.
- R2: The displacements u and v each take every value from -P to P-1. The reported `mv_u` and `mv_v` are two's-complement values within that range.
- R3: A pulse on `start` in ST_IDLE begins a run. The engine then accepts N current rows, top row first, one per cycle that has `cur_valid` high. Pixel j of a row sits at `cur_row[j*PIX_W +: PIX_W]`, and its mask bit is `cur_mask[j]`.
- R4: The reference window is streamed in 2P bands, indexed by k = u+P from 0 to 2P-1. Each band carries window columns c from -P to P+N-2 in increasing order. Element i of a column sits at `ref_col[i*PIX_W +: PIX_W]` and holds W(k-P+i, c). The first N-1 columns of a band only fill the array. A cycle with `ref_valid` low stalls the engine without changing the result.
- R5: A masked element adds nothing to its column sum, and its gated reference register keeps its value. Changing current pixels at masked positions therefore leaves the result unchanged.
- R6: The selector keeps a new score only when it is strictly below the running minimum. On equal scores, the displacement reached first in u-outer, v-inner ascending order is reported.
- R7: `done` is high for exactly one cycle, on the third rising edge after the edge that accepts the final reference column. On that cycle `mv_u`, `mv_v` and `min_ssad` carry the result, and they hold their values until the next run produces a new result.
- R8: After reset, `done` is 0, and `mv_u`, `mv_v` and `min_ssad` are 0.
- R9: Each run starts from a cleared minimum, so the result of one run never depends on the run before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run when the engine is idle |
| cur_valid | input | 1 | A current-block row is present |
| cur_row | input | BLK_N*PIX_W | One row of current pixels, pixel j at bits j*PIX_W |
| cur_mask | input | BLK_N | Mask bits for the row, bit j for pixel j |
| ref_valid | input | 1 | A reference window column is present |
| ref_col | input | BLK_N*PIX_W | One window column, element i at bits i*PIX_W |
| done | output | 1 | One-cycle result pulse |
| mv_u | output | $clog2(SRCH_P)+1 | Best vertical displacement, signed |
| mv_v | output | $clog2(SRCH_P)+1 | Best horizontal displacement, signed |
| min_ssad | output | PIX_W+$clog2(BLK_N*BLK_N+1) | Score of the best displacement |

## Verification
A wrong column or band count in the controller misaligns which window column sits under which element. That error surfaces as a wrong score or a wrong displacement at the next `done`, and the `done` pulse itself arrives early or late. A masked element that still switches, or that leaks its frozen value, changes `min_ssad` as soon as the masked current pixels are altered between two otherwise identical runs. A minimum that is not cleared, or a selector that replaces on ties, shows in the first run after a low-scoring run, and in flat-content runs where every displacement scores the same.

// File: rtl/ssad_pkg.sv
package ssad_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD_CUR,
        ST_FILL_REF,
        ST_SCAN,
        ST_DRAIN
    } ssad_state_e;

    function automatic int sum_width(input int pix_w, input int terms);
        return pix_w + $clog2(terms + 1);
    endfunction

endpackage

// File: rtl/ssad_pe.sv
module ssad_pe #(
    parameter int PIX_W = 8,
    parameter int CSW   = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cur_we,
    input  logic [PIX_W-1:0] cur_in,
    input  logic             mask_in,
    input  logic             shift_en,
    input  logic [PIX_W-1:0] ref_in,
    output logic [PIX_W-1:0] ref_out,
    input  logic [CSW-1:0]   psum_in,
    output logic [CSW-1:0]   psum_out
);

    logic [PIX_W-1:0] cur_q;
    logic             mask_q;
    logic [PIX_W-1:0] ref_q;
    logic [PIX_W-1:0] blk_q;
    logic [PIX_W-1:0] diff;
    logic [PIX_W-1:0] gated;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            mask_q <= 1'b0;
            ref_q  <= '0;
            blk_q  <= '0;
        end else begin
            if (cur_we) begin
                cur_q  <= cur_in;
                mask_q <= mask_in;
            end
            if (shift_en) begin
                ref_q <= ref_in;
            end
            if (shift_en && mask_q) begin
                blk_q <= ref_in;
            end
        end
    end

    always_comb begin
        diff     = (cur_q >= blk_q) ? (cur_q - blk_q) : (blk_q - cur_q);
        gated    = mask_q ? diff : '0;
        psum_out = psum_in + CSW'(gated);
        ref_out  = ref_q;
    end

    // R5: a masked element keeps its gated reference register still
    a_r5_masked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_q && !cur_we) |=> $stable(blk_q));

    // R1: the partial sum never shrinks on its way down the column
    a_r1_psum_grows: assert property (@(posedge clk) disable iff (!rst_n)
        psum_out >= psum_in);

endmodule

// File: rtl/ssad_ctrl.sv
module ssad_ctrl
    import ssad_pkg::*;
#(
    parameter int BLK_N  = 16,
    parameter int SRCH_P = 32,
    parameter int OW     = $clog2(SRCH_P) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 cur_valid,
    input  logic                 ref_valid,
    input  logic                 fin,
    output logic [BLK_N-1:0]     cur_row_we,
    output logic                 shift_en,
    output logic                 clear_best,
    output logic                 cand_valid,
    output logic                 cand_last,
    output logic signed [OW-1:0] cand_u,
    output logic signed [OW-1:0] cand_v
);

    localparam int COLS = 2 * SRCH_P + BLK_N - 1;
    localparam int BANDS = 2 * SRCH_P;
    localparam int CCW  = $clog2(COLS + 1);
    localparam int UW   = $clog2(BANDS + 1);
    localparam int RW   = $clog2(BLK_N + 1);
    localparam logic [CCW-1:0] COL_LAST = CCW'(COLS - 1);
    localparam logic [CCW-1:0] FILL_LAST = CCW'(BLK_N - 2);
    localparam logic [UW-1:0]  BAND_LAST = UW'(BANDS - 1);
    localparam logic [RW-1:0]  ROW_LAST = RW'(BLK_N - 1);

    ssad_state_e state_q, state_d;
    logic [RW-1:0]  row_cnt;
    logic [CCW-1:0] col_cnt;
    logic [UW-1:0]  band_q;
    logic           band_end;
    logic           run_end;
    logic signed [OW-1:0] u_off;
    logic signed [OW-1:0] v_off;

    assign band_end = (col_cnt == COL_LAST);
    assign run_end  = band_end && (band_q == BAND_LAST);
    assign u_off    = OW'(int'(band_q) - SRCH_P);
    assign v_off    = OW'(int'(col_cnt) - (BLK_N - 1) - SRCH_P);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_LOAD_CUR;
            end
            ST_LOAD_CUR: begin
                if (cur_valid && row_cnt == ROW_LAST) state_d = ST_FILL_REF;
            end
            ST_FILL_REF: begin
                if (ref_valid && col_cnt == FILL_LAST) state_d = ST_SCAN;
            end
            ST_SCAN: begin
                if (ref_valid && band_end) begin
                    state_d = run_end ? ST_DRAIN : ST_FILL_REF;
                end
            end
            ST_DRAIN: begin
                if (fin) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        clear_best = (state_q == ST_IDLE) && start;
        shift_en   = ref_valid && (state_q == ST_FILL_REF || state_q == ST_SCAN);
        for (int r = 0; r < BLK_N; r++) begin
            cur_row_we[r] = (state_q == ST_LOAD_CUR) && cur_valid && (row_cnt == RW'(r));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_cnt    <= '0;
            col_cnt    <= '0;
            band_q     <= '0;
            cand_valid <= 1'b0;
            cand_last  <= 1'b0;
            cand_u     <= '0;
            cand_v     <= '0;
        end else begin
            cand_valid <= shift_en && (state_q == ST_SCAN);
            cand_last  <= shift_en && (state_q == ST_SCAN) && run_end;
            if (shift_en && state_q == ST_SCAN) begin
                cand_u <= u_off;
                cand_v <= v_off;
            end
            if (clear_best) begin
                row_cnt <= '0;
                col_cnt <= '0;
                band_q  <= '0;
            end else begin
                if (state_q == ST_LOAD_CUR && cur_valid) begin
                    row_cnt <= row_cnt + 1'b1;
                end
                if (shift_en) begin
                    if (state_q == ST_SCAN && band_end) begin
                        col_cnt <= '0;
                        band_q  <= band_q + 1'b1;
                    end else begin
                        col_cnt <= col_cnt + 1'b1;
                    end
                end
            end
        end
    end

    // R4: fill columns never issue a candidate
    a_r4_fill_no_cand: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL_REF) |=> !cand_valid);

    // R4: the column counter stays within one band
    a_r4_col_bound: assert property (@(posedge clk) disable iff (!rst_n)
        col_cnt <= COL_LAST);

    // R3: at most one current row is written per cycle
    a_r3_one_row: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cur_row_we));

    // R2: candidates carry in-range displacements
    a_r2_cand_range: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> (int'(cand_u) >= -SRCH_P && int'(cand_u) < SRCH_P &&
                        int'(cand_v) >= -SRCH_P && int'(cand_v) < SRCH_P));

endmodule

// File: rtl/ssad_sum_tree.sv
module ssad_sum_tree #(
    parameter int BLK_N = 16,
    parameter int PIX_W = 8,
    parameter int CSW   = 13,
    parameter int SSW   = 17,
    parameter int OW    = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [BLK_N*CSW-1:0]   col_flat,
    input  logic                   in_valid,
    input  logic                   in_last,
    input  logic signed [OW-1:0]   in_u,
    input  logic signed [OW-1:0]   in_v,
    output logic                   out_valid,
    output logic                   out_last,
    output logic signed [OW-1:0]   out_u,
    output logic signed [OW-1:0]   out_v,
    output logic [SSW-1:0]         out_sum
);

    localparam int NP = 1 << $clog2(BLK_N);
    localparam logic [SSW-1:0] MAX_SUM = SSW'(BLK_N * BLK_N * ((1 << PIX_W) - 1));

    logic [CSW-1:0] col_q [BLK_N];
    logic           s1_valid;
    logic           s1_last;
    logic signed [OW-1:0] s1_u;
    logic signed [OW-1:0] s1_v;
    logic [SSW-1:0] node [2*NP-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_last  <= 1'b0;
            s1_u     <= '0;
            s1_v     <= '0;
            for (int k = 0; k < BLK_N; k++) col_q[k] <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_last  <= in_last;
            if (in_valid) begin
                s1_u <= in_u;
                s1_v <= in_v;
                for (int k = 0; k < BLK_N; k++) col_q[k] <= col_flat[k*CSW +: CSW];
            end
        end
    end

    always_comb begin
        for (int k = 0; k < NP; k++) begin
            if (k < BLK_N) node[NP-1+k] = SSW'(col_q[k]);
            else           node[NP-1+k] = '0;
        end
        for (int n = NP - 2; n >= 0; n--) begin
            node[n] = node[2*n+1] + node[2*n+2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_u     <= '0;
            out_v     <= '0;
            out_sum   <= '0;
        end else begin
            out_valid <= s1_valid;
            out_last  <= s1_last;
            if (s1_valid) begin
                out_u   <= s1_u;
                out_v   <= s1_v;
                out_sum <= node[0];
            end
        end
    end

    // R1: a block score can never exceed every pixel differing by full scale
    a_r1_sum_bound: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_sum <= MAX_SUM);

    // R7: the final tag travels through both stages in step
    a_r7_last_follows: assert property (@(posedge clk) disable iff (!rst_n)
        s1_last |=> out_last);

endmodule

// File: rtl/ssad_min_sel.sv
module ssad_min_sel #(
    parameter int SSW = 17,
    parameter int OW  = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 in_valid,
    input  logic                 in_last,
    input  logic signed [OW-1:0] in_u,
    input  logic signed [OW-1:0] in_v,
    input  logic [SSW-1:0]       in_sum,
    output logic                 done,
    output logic signed [OW-1:0] best_u,
    output logic signed [OW-1:0] best_v,
    output logic [SSW-1:0]       best_sum
);

    logic have_q;
    logic take;

    assign take = in_valid && (!have_q || in_sum < best_sum);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_q   <= 1'b0;
            done     <= 1'b0;
            best_u   <= '0;
            best_v   <= '0;
            best_sum <= '0;
        end else begin
            done <= in_valid && in_last && !clear;
            if (clear) begin
                have_q <= 1'b0;
            end else if (in_valid) begin
                have_q <= 1'b1;
                if (take) begin
                    best_u   <= in_u;
                    best_v   <= in_v;
                    best_sum <= in_sum;
                end
            end
        end
    end

    // R6: the kept minimum never rises within a run
    a_r6_min_nonincr: assert property (@(posedge clk) disable iff (!rst_n)
        (have_q && in_valid && !clear) |=> best_sum <= $past(best_sum));

    // R6: an equal or larger score leaves the kept displacement alone
    a_r6_tie_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (have_q && in_valid && !clear && in_sum >= best_sum)
            |=> ($stable(best_u) && $stable(best_v)));

    // R7: the result strobe lasts one cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/ssad_matcher.sv
module ssad_matcher
    import ssad_pkg::*;
#(
    parameter int BLK_N  = 16,
    parameter int SRCH_P = 32,
    parameter int PIX_W  = 8,
    localparam int OW    = $clog2(SRCH_P) + 1,
    localparam int CSW   = sum_width(PIX_W, BLK_N),
    localparam int SSW   = sum_width(PIX_W, BLK_N * BLK_N)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     cur_valid,
    input  logic [BLK_N*PIX_W-1:0]   cur_row,
    input  logic [BLK_N-1:0]         cur_mask,
    input  logic                     ref_valid,
    input  logic [BLK_N*PIX_W-1:0]   ref_col,
    output logic                     done,
    output logic signed [OW-1:0]     mv_u,
    output logic signed [OW-1:0]     mv_v,
    output logic [SSW-1:0]           min_ssad
);

    logic [BLK_N-1:0]  cur_row_we;
    logic              shift_en;
    logic              clear_best;
    logic              cand_valid;
    logic              cand_last;
    logic signed [OW-1:0] cand_u;
    logic signed [OW-1:0] cand_v;
    logic              tree_valid;
    logic              tree_last;
    logic signed [OW-1:0] tree_u;
    logic signed [OW-1:0] tree_v;
    logic [SSW-1:0]    tree_sum;
    logic [BLK_N*CSW-1:0] col_flat;

    logic [PIX_W-1:0] ref_in_w  [BLK_N][BLK_N];
    logic [PIX_W-1:0] ref_out_w [BLK_N][BLK_N];
    logic [CSW-1:0]   psum_in_w [BLK_N][BLK_N];
    logic [CSW-1:0]   psum_out_w[BLK_N][BLK_N];

    ssad_ctrl #(
        .BLK_N (BLK_N),
        .SRCH_P(SRCH_P),
        .OW    (OW)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cur_valid (cur_valid),
        .ref_valid (ref_valid),
        .fin       (tree_valid && tree_last),
        .cur_row_we(cur_row_we),
        .shift_en  (shift_en),
        .clear_best(clear_best),
        .cand_valid(cand_valid),
        .cand_last (cand_last),
        .cand_u    (cand_u),
        .cand_v    (cand_v)
    );

    for (genvar i = 0; i < BLK_N; i++) begin : g_row
        for (genvar j = 0; j < BLK_N; j++) begin : g_col
            if (j == BLK_N - 1) begin : g_ref_edge
                assign ref_in_w[i][j] = ref_col[i*PIX_W +: PIX_W];
            end else begin : g_ref_chain
                assign ref_in_w[i][j] = ref_out_w[i][j+1];
            end
            if (i == 0) begin : g_sum_top
                assign psum_in_w[i][j] = '0;
            end else begin : g_sum_chain
                assign psum_in_w[i][j] = psum_out_w[i-1][j];
            end

            ssad_pe #(
                .PIX_W(PIX_W),
                .CSW  (CSW)
            ) u_pe (
                .clk     (clk),
                .rst_n   (rst_n),
                .cur_we  (cur_row_we[i]),
                .cur_in  (cur_row[j*PIX_W +: PIX_W]),
                .mask_in (cur_mask[j]),
                .shift_en(shift_en),
                .ref_in  (ref_in_w[i][j]),
                .ref_out (ref_out_w[i][j]),
                .psum_in (psum_in_w[i][j]),
                .psum_out(psum_out_w[i][j])
            );
        end
        assign col_flat[i*CSW +: CSW] = psum_out_w[BLK_N-1][i];
    end

    ssad_sum_tree #(
        .BLK_N(BLK_N),
        .PIX_W(PIX_W),
        .CSW  (CSW),
        .SSW  (SSW),
        .OW   (OW)
    ) u_tree (
        .clk      (clk),
        .rst_n    (rst_n),
        .col_flat (col_flat),
        .in_valid (cand_valid),
        .in_last  (cand_last),
        .in_u     (cand_u),
        .in_v     (cand_v),
        .out_valid(tree_valid),
        .out_last (tree_last),
        .out_u    (tree_u),
        .out_v    (tree_v),
        .out_sum  (tree_sum)
    );

    ssad_min_sel #(
        .SSW(SSW),
        .OW (OW)
    ) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear_best),
        .in_valid(tree_valid),
        .in_last (tree_last),
        .in_u    (tree_u),
        .in_v    (tree_v),
        .in_sum  (tree_sum),
        .done    (done),
        .best_u  (mv_u),
        .best_v  (mv_v),
        .best_sum(min_ssad)
    );

    // R2: the reported displacement lies inside the search range
    a_r2_mv_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(mv_u) >= -SRCH_P && int'(mv_u) < SRCH_P &&
                  int'(mv_v) >= -SRCH_P && int'(mv_v) < SRCH_P));

    // R7: outputs hold between result strobes unless a new candidate lands
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tree_valid && !done) |=> $stable(min_ssad));

endmodule

// File: tb/ssad_matcher_tb.sv
module ssad_matcher_tb;

    localparam int N    = 4;
    localparam int P    = 2;
    localparam int PW   = 8;
    localparam int WS   = 2 * P + N - 1;
    localparam int OW   = $clog2(P) + 1;
    localparam int SSW  = PW + $clog2(N * N + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cur_valid = 1'b0;
    logic [N*PW-1:0] cur_row = '0;
    logic [N-1:0] cur_mask = '0;
    logic ref_valid = 1'b0;
    logic [N*PW-1:0] ref_col = '0;
    logic done;
    logic signed [OW-1:0] mv_u;
    logic signed [OW-1:0] mv_v;
    logic [SSW-1:0] min_ssad;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int cur_px [N][N];
    int msk    [N][N];
    int win    [WS][WS];
    int got_sum, got_u, got_v;

    always #2 clk = ~clk;

    ssad_matcher #(.BLK_N(N), .SRCH_P(P), .PIX_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cur_valid(cur_valid),
        .cur_row(cur_row), .cur_mask(cur_mask), .ref_valid(ref_valid),
        .ref_col(ref_col), .done(done), .mv_u(mv_u), .mv_v(mv_v),
        .min_ssad(min_ssad)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic void expect_search(output int bs, output int bu, output int bv);
        bit first = 1'b1;
        bs = 0; bu = 0; bv = 0;
        for (int u = -P; u < P; u++) begin
            for (int v = -P; v < P; v++) begin
                int s = 0;
                for (int i = 0; i < N; i++) begin
                    for (int j = 0; j < N; j++) begin
                        if (msk[i][j] != 0) begin
                            int d = win[i+u+P][j+v+P] - cur_px[i][j];
                            s += (d < 0) ? -d : d;
                        end
                    end
                end
                if (first || s < bs) begin
                    bs = s; bu = u; bv = v; first = 1'b0;
                end
            end
        end
    endfunction

    task automatic run_engine(input int stall_pct, input string req);
        int lat;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int r = 0; r < N; r++) begin
            cur_valid = 1'b1;
            for (int j = 0; j < N; j++) begin
                cur_row[j*PW +: PW] = PW'(cur_px[r][j]);
                cur_mask[j] = (msk[r][j] != 0);
            end
            @(negedge clk);
        end
        cur_valid = 1'b0;
        for (int k = 0; k < 2 * P; k++) begin
            for (int c = 0; c < WS; c++) begin
                while (int'($urandom_range(99)) < stall_pct) begin
                    ref_valid = 1'b0;
                    ref_col = PW'($urandom) * '1;
                    @(negedge clk);
                end
                ref_valid = 1'b1;
                for (int i = 0; i < N; i++) ref_col[i*PW +: PW] = PW'(win[k+i][c]);
                @(negedge clk);
            end
        end
        ref_valid = 1'b0;
        lat = 0;
        while (lat < 20) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (done) break;
        end
        check(lat == 3, "R7 latency", lat, 3);
        got_sum = int'(min_ssad);
        got_u = int'(mv_u);
        got_v = int'(mv_v);
        @(negedge clk);
        check(done == 1'b0, "R7 pulse", int'(done), 0);
        check(int'(min_ssad) == got_sum, "R7 hold", int'(min_ssad), got_sum);
    endtask

    task automatic run_and_compare(input int stall_pct, input string req);
        int es, eu, ev;
        expect_search(es, eu, ev);
        run_engine(stall_pct, req);
        check(got_sum == es, {req, " ssad"}, got_sum, es);
        check(got_u == eu, {req, " mv_u"}, got_u, eu);
        check(got_v == ev, {req, " mv_v"}, got_v, ev);
    endtask

    task automatic fill_random(input int mask_pct);
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                cur_px[i][j] = int'($urandom_range(255));
                msk[i][j] = (int'($urandom_range(99)) < mask_pct) ? 1 : 0;
            end
        for (int r = 0; r < WS; r++)
            for (int c = 0; c < WS; c++) win[r][c] = int'($urandom_range(255));
    endtask

    initial begin
        int ref_s, ref_u, ref_v;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        check(done == 1'b0, "R8 done", int'(done), 0);
        check(min_ssad == '0, "R8 min_ssad", int'(min_ssad), 0);
        check(mv_u == '0 && mv_v == '0, "R8 mv", int'(mv_u), 0);

        // R1: full mask, random content
        fill_random(100);
        run_and_compare(0, "R1 full mask");

        // R1 R3 R4: random masks with stalls on the reference stream
        for (int t = 0; t < 6; t++) begin
            fill_random(50);
            run_and_compare(30, "R4 stalled random");
        end

        // R5 R6: empty mask, every score zero, first displacement kept
        fill_random(0);
        run_and_compare(10, "R5 empty mask");
        check(got_u == -P && got_v == -P, "R6 first on tie", got_u, -P);

        // R9: a run after a zero result must start fresh
        fill_random(100);
        run_and_compare(0, "R9 fresh start");
        check(got_sum > 0, "R9 nonzero", got_sum, 1);

        // R6: flat window, all scores equal and nonzero
        fill_random(100);
        for (int r = 0; r < WS; r++)
            for (int c = 0; c < WS; c++) win[r][c] = 10;
        for (int i = 0; i < N; i++) cur_px[i][0] = 200;
        run_and_compare(0, "R6 flat tie");

        // R2: planted exact match at the last band, leftmost column
        fill_random(100);
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) win[i + (P-1) + P][j] = cur_px[i][j];
        run_and_compare(20, "R2 planted");
        check(got_u == P - 1 && got_v == -P, "R2 corner", got_u, P - 1);

        // R1: full-scale difference everywhere
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin cur_px[i][j] = 255; msk[i][j] = 1; end
        for (int r = 0; r < WS; r++)
            for (int c = 0; c < WS; c++) win[r][c] = 0;
        run_and_compare(0, "R1 full scale");

        // R5: masked current pixels have no effect on the result
        fill_random(40);
        run_and_compare(0, "R5 base");
        ref_s = got_sum; ref_u = got_u; ref_v = got_v;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                if (msk[i][j] == 0) cur_px[i][j] = int'($urandom_range(255));
        run_engine(25, "R5 altered");
        check(got_sum == ref_s, "R5 masked sum", got_sum, ref_s);
        check(got_u == ref_u && got_v == ref_v, "R5 masked mv", got_u, ref_u);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule